// File: doc/BRIEF.md
# Power Delivery Transmit Request Sequencer

This block drives the transmit side of a USB Power Delivery physical layer at the message level. Software chooses a message type, programs a 20-bit ordered set and a payload byte count, and then issues either a send command or a hard-reset command. The block passes a stream of items to a downstream serializer over a valid/ready handshake. For a normal packet the stream is the ordered set, then each payload byte in the order written, then an end-of-packet request. Line coding, CRC and DMA belong to other blocks.

Payload bytes arrive through a one-byte holding register. The block counts the bytes still owed and raises a data-request flag while that register is empty and bytes remain. If the serializer wants a byte that has not arrived, the block reports an underrun. Sticky status flags report each outcome: message sent, discarded, aborted, hard reset sent, hard reset discarded, and underrun. Software clears each flag by writing one to the matching bit of a clear vector.

A hard-reset request has priority over a send. It also preempts a message that is in progress. A send that finds the receiver busy or the line noisy is dropped, and its discard flag is raised only once the line is idle. Removing the enable returns everything to the reset state.

Top module: `pd_tx_sequencer`

## Requirements
- R1: `mode` selects the message: 0 sends the packet (serializer kinds ORDSET=0 carrying `ordset`, DATA=1 carrying each byte zero-extended, EOP=2). 1 sends a single CRST=4 item. 2 starts the carrier test pattern (BIST=5). 3 is invalid: the send is dropped and sets the discard flag (flags[0]).
- R2: `send_pend` and `hrst_pend` are set by their request pulses and are cleared by hardware when the request starts or is discarded. A pending send is therefore visible for exactly one cycle when the sequencer is idle.
- R3: `pay_left` is loaded by `size_wr`, which is ignored during a packet. It decreases by one for each accepted `data_wr`. A write is ignored while the holding register is full or `pay_left` is zero.
- R4: `txreq` is high during a packet while the holding register is empty and `pay_left` is non-zero. An accepted write clears it in the next cycle.
- R5: If the serializer is ready in the data phase, the holding register is empty, bytes are still owed and no write arrives in that cycle, then underrun (flags[5]) is set. The message ends without EOP and without the sent flag.
- R6: A send that finds `rx_busy` or `line_noisy` high is dropped, and `send_pend` clears. The discard flag (flags[0]) is raised only in a cycle where `line_idle` is high, and nothing is handed to the serializer.
- R7: A hard-reset request during a packet or cable reset aborts it: abort (flags[2]) is set, the HRST=3 item follows, and sent (flags[1]) is not set for that message.
- R8: A hard reset with `rx_busy` or `line_noisy` high sets hard-reset-discarded (flags[3]). Otherwise it sends HRST and sets hard-reset-sent (flags[4]). When both commands are pending, the hard reset goes first.
- R9: Once started, the carrier test pattern holds `ser_valid` with kind BIST for as long as `en` stays high.
- R10: With `en` low, the sequencer goes idle: pending commands, count, holding register and all flags clear in the next cycle.
- R11: A flag stays set until a one on its `flag_clr` bit clears it. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low forces idle and clears all state |
| mode | input | 2 | Message type for the next send |
| ordset | input | 20 | Ordered set for a packet |
| size_wr | input | 1 | Load strobe for the payload count |
| size_val | input | 10 | Payload byte count (header included, CRC excluded) |
| data_wr | input | 1 | Payload byte write strobe |
| data_val | input | 8 | Payload byte |
| send_req | input | 1 | Send command pulse |
| hrst_req | input | 1 | Hard-reset command pulse |
| rx_busy | input | 1 | Receiver is busy with a message |
| line_noisy | input | 1 | Excessive noise on the line |
| line_idle | input | 1 | Line is idle |
| ser_ready | input | 1 | Serializer accepts the current item |
| ser_valid | output | 1 | An item is offered to the serializer |
| ser_kind | output | 3 | Item kind: 0 ordset, 1 data, 2 EOP, 3 hard reset, 4 cable reset, 5 carrier test |
| ser_data | output | 20 | Ordered set, or data byte zero-extended |
| send_pend | output | 1 | Send command bit |
| hrst_pend | output | 1 | Hard-reset command bit |
| txreq | output | 1 | Data request |
| pay_left | output | 10 | Payload bytes still to be written |
| flags | output | 6 | 0 discard, 1 sent, 2 abort, 3 hrst discarded, 4 hrst sent, 5 underrun |
| flag_clr | input | 6 | Write-one-to-clear, one bit per flag |

## Verification
Two functions can meet in the same cycle. A hard-reset request can arrive while the ordered set is on offer, and a data write can arrive in the cycle in which the serializer is already waiting on an empty holding register. The bench provokes the first by holding `ser_ready` low during the ordered-set phase, then pulsing the hard reset. It judges the result by the logged item stream, which must contain only HRST, and by the abort, sent and hrst-sent flags. It provokes the second by writing each byte as soon as `txreq` rises while the serializer stays ready. That run must complete the packet without underrun, while a run that withholds the byte must report underrun.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAITIDLE = 3'd1,
        ST_ORDSET   = 3'd2,
        ST_DATA     = 3'd3,
        ST_EOP      = 3'd4,
        ST_CRST     = 3'd5,
        ST_HRST     = 3'd6,
        ST_BIST     = 3'd7
    } state_e;

    localparam logic [2:0] K_ORDSET = 3'd0;
    localparam logic [2:0] K_DATA   = 3'd1;
    localparam logic [2:0] K_EOP    = 3'd2;
    localparam logic [2:0] K_HRST   = 3'd3;
    localparam logic [2:0] K_CRST   = 3'd4;
    localparam logic [2:0] K_BIST   = 3'd5;

    localparam logic [1:0] MODE_PKT  = 2'd0;
    localparam logic [1:0] MODE_CRST = 2'd1;
    localparam logic [1:0] MODE_BIST = 2'd2;

    localparam int NFLAG  = 6;
    localparam int F_DISC = 0;
    localparam int F_SENT = 1;
    localparam int F_ABT  = 2;
    localparam int F_HDSC = 3;
    localparam int F_HSNT = 4;
    localparam int F_UND  = 5;

endpackage

// File: rtl/pd_tx_flags.sv
module pd_tx_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = en ? ((flags_q & ~clr) | set) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (en && clr[i] && !set[i]) |=> !flags_q[i]);
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (en && set[i]) |=> flags_q[i]);
        p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !flags_q[i]);
    end
endmodule

// File: rtl/pd_tx_payload.sv
module pd_tx_payload #(
    parameter int CNT_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              size_wr,
    input  logic [CNT_W-1:0]  size_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_val,
    input  logic              in_msg,
    input  logic              take,
    input  logic              flush,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero,
    output logic              buf_full,
    output logic [BYTE_W-1:0] buf_byte,
    output logic              txreq,
    output logic              wr_ok
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic [BYTE_W-1:0] byte_v;
        logic              txreq;
    } pay_s;

    pay_s r_d, r_q;

    assign wr_ok = data_wr && !r_q.full && (r_q.cnt != '0);

    always_comb begin
        r_d = r_q;
        if (size_wr && !in_msg) r_d.cnt = size_val;
        if (take) r_d.full = 1'b0;
        if (wr_ok) begin
            r_d.full   = 1'b1;
            r_d.byte_v = data_val;
            r_d.cnt    = r_q.cnt - 1'b1;
        end
        if (flush) begin
            r_d.cnt  = '0;
            r_d.full = 1'b0;
        end
        r_d.txreq = in_msg && !r_d.full && (r_d.cnt != '0);
        if (!en) r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt      = r_q.cnt;
    assign cnt_zero = (r_q.cnt == '0);
    assign buf_full = r_q.full;
    assign buf_byte = r_q.byte_v;
    assign txreq    = r_q.txreq;

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_ok && !flush) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
    p_full_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && data_wr && r_q.full && !take && !flush) |=> $stable(r_q.byte_v));
    p_write_drops_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_ok) |=> !r_q.txreq);
endmodule

// File: rtl/pd_tx_fsm.sv
module pd_tx_fsm
    import pd_tx_pkg::*;
#(
    parameter int ORD_W  = 20,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              send_req,
    input  logic              hrst_req,
    input  logic [1:0]        mode,
    input  logic [ORD_W-1:0]  ordset,
    input  logic              rx_busy,
    input  logic              line_noisy,
    input  logic              line_idle,
    input  logic              ser_ready,
    input  logic              cnt_zero,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_byte,
    input  logic              wr_ok,
    output logic              send_pend,
    output logic              hrst_pend,
    output logic              in_msg,
    output logic              take,
    output logic              flush,
    output logic [NFLAG-1:0]  flag_set,
    output logic              ser_valid,
    output logic [2:0]        ser_kind,
    output logic [ORD_W-1:0]  ser_data
);
    typedef struct packed {
        state_e st;
        logic   send;
        logic   hrst;
    } fsm_s;

    fsm_s r_d, r_q;
    logic line_bad;
    logic in_frame;

    assign line_bad = rx_busy || line_noisy;
    assign in_frame = (r_q.st == ST_ORDSET) || (r_q.st == ST_DATA) ||
                      (r_q.st == ST_EOP) || (r_q.st == ST_CRST);

    always_comb begin
        r_d      = r_q;
        r_d.send = r_q.send | send_req;
        r_d.hrst = r_q.hrst | hrst_req;
        flag_set = '0;
        take     = 1'b0;
        flush    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.hrst) begin
                    r_d.hrst = hrst_req;
                    if (line_bad) flag_set[F_HDSC] = 1'b1;
                    else          r_d.st = ST_HRST;
                end else if (r_q.send) begin
                    r_d.send = send_req;
                    if (line_bad || mode == 2'd3) r_d.st = ST_WAITIDLE;
                    else if (mode == MODE_PKT)    r_d.st = ST_ORDSET;
                    else if (mode == MODE_CRST)   r_d.st = ST_CRST;
                    else                          r_d.st = ST_BIST;
                end
            end
            ST_WAITIDLE: begin
                if (line_idle) begin
                    flag_set[F_DISC] = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            ST_HRST: begin
                if (ser_ready) begin
                    flag_set[F_HSNT] = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            ST_BIST: r_d.st = ST_BIST;
            default: begin
                if (r_q.hrst) begin
                    r_d.hrst = hrst_req;
                    flag_set[F_ABT] = 1'b1;
                    flush = 1'b1;
                    r_d.st = ST_HRST;
                end else begin
                    case (r_q.st)
                        ST_ORDSET: if (ser_ready)
                            r_d.st = (buf_full || !cnt_zero) ? ST_DATA : ST_EOP;
                        ST_DATA: begin
                            if (buf_full) begin
                                if (ser_ready) begin
                                    take = 1'b1;
                                    if (cnt_zero) r_d.st = ST_EOP;
                                end
                            end else if (cnt_zero) begin
                                r_d.st = ST_EOP;
                            end else if (ser_ready && !wr_ok) begin
                                flag_set[F_UND] = 1'b1;
                                flush = 1'b1;
                                r_d.st = ST_IDLE;
                            end
                        end
                        ST_EOP, ST_CRST: if (ser_ready) begin
                            flag_set[F_SENT] = 1'b1;
                            flush = 1'b1;
                            r_d.st = ST_IDLE;
                        end
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
        endcase
        if (!en) begin
            r_d      = '0;
            flag_set = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ser_valid = 1'b0;
        ser_kind  = K_ORDSET;
        ser_data  = '0;
        case (r_q.st)
            ST_ORDSET: begin ser_valid = !r_q.hrst; ser_data = ordset; end
            ST_DATA: begin
                ser_valid = buf_full && !r_q.hrst;
                ser_kind  = K_DATA;
                ser_data  = {{(ORD_W-BYTE_W){1'b0}}, buf_byte};
            end
            ST_EOP:  begin ser_valid = !r_q.hrst; ser_kind = K_EOP;  end
            ST_CRST: begin ser_valid = !r_q.hrst; ser_kind = K_CRST; end
            ST_HRST: begin ser_valid = 1'b1;      ser_kind = K_HRST; end
            ST_BIST: begin ser_valid = 1'b1;      ser_kind = K_BIST; end
            default: ser_valid = 1'b0;
        endcase
    end

    assign send_pend = r_q.send;
    assign hrst_pend = r_q.hrst;
    assign in_msg    = (r_q.st == ST_ORDSET) || (r_q.st == ST_DATA);

    p_hrst_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && r_q.st == ST_IDLE && r_q.hrst && !hrst_req) |=> !r_q.hrst);
    p_no_sent_on_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_set[F_SENT] && flag_set[F_ABT]));
    p_abort_leads_hrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_frame && r_q.hrst) |=> (r_q.st == ST_HRST));
    p_disc_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[F_DISC] |-> line_idle);
    p_bist_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && r_q.st == ST_BIST) |=> (r_q.st == ST_BIST));
    p_off_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (r_q.st == ST_IDLE && !r_q.send && !r_q.hrst));
endmodule

// File: rtl/pd_tx_sequencer.sv
module pd_tx_sequencer
    import pd_tx_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ORD_W  = 20,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [ORD_W-1:0]  ordset,
    input  logic              size_wr,
    input  logic [CNT_W-1:0]  size_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_val,
    input  logic              send_req,
    input  logic              hrst_req,
    input  logic              rx_busy,
    input  logic              line_noisy,
    input  logic              line_idle,
    input  logic              ser_ready,
    output logic              ser_valid,
    output logic [2:0]        ser_kind,
    output logic [ORD_W-1:0]  ser_data,
    output logic              send_pend,
    output logic              hrst_pend,
    output logic              txreq,
    output logic [CNT_W-1:0]  pay_left,
    output logic [NFLAG-1:0]  flags,
    input  logic [NFLAG-1:0]  flag_clr
);
    logic              in_msg, take, flush, cnt_zero, buf_full, wr_ok;
    logic [BYTE_W-1:0] buf_byte;
    logic [NFLAG-1:0]  flag_set;

    pd_tx_payload #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_pay (
        .clk(clk), .rst_n(rst_n), .en(en),
        .size_wr(size_wr), .size_val(size_val),
        .data_wr(data_wr), .data_val(data_val),
        .in_msg(in_msg), .take(take), .flush(flush),
        .cnt(pay_left), .cnt_zero(cnt_zero), .buf_full(buf_full),
        .buf_byte(buf_byte), .txreq(txreq), .wr_ok(wr_ok)
    );

    pd_tx_fsm #(.ORD_W(ORD_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en),
        .send_req(send_req), .hrst_req(hrst_req), .mode(mode), .ordset(ordset),
        .rx_busy(rx_busy), .line_noisy(line_noisy), .line_idle(line_idle),
        .ser_ready(ser_ready), .cnt_zero(cnt_zero), .buf_full(buf_full),
        .buf_byte(buf_byte), .wr_ok(wr_ok),
        .send_pend(send_pend), .hrst_pend(hrst_pend), .in_msg(in_msg),
        .take(take), .flush(flush), .flag_set(flag_set),
        .ser_valid(ser_valid), .ser_kind(ser_kind), .ser_data(ser_data)
    );

    pd_tx_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .en(en),
        .set(flag_set), .clr(flag_clr), .flags(flags)
    );
endmodule

// File: tb/test_pd_tx_sequencer.sv
module test_pd_tx_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [19:0] ordset = 20'h5A3C1;
    logic        size_wr = 1'b0;
    logic [9:0]  size_val = '0;
    logic        data_wr = 1'b0;
    logic [7:0]  data_val = '0;
    logic        send_req = 1'b0, hrst_req = 1'b0;
    logic        rx_busy = 1'b0, line_noisy = 1'b0, line_idle = 1'b1;
    logic        ser_ready = 1'b1;
    logic        ser_valid, send_pend, hrst_pend, txreq;
    logic [2:0]  ser_kind;
    logic [19:0] ser_data;
    logic [9:0]  pay_left;
    logic [5:0]  flags;
    logic [5:0]  flag_clr = '0;

    int errors = 0, checks = 0, ln = 0;
    bit done = 0;
    logic [2:0]  lk [0:31];
    logic [19:0] ld [0:31];

    always #10 clk = ~clk;

    pd_tx_sequencer i_pd_tx_sequencer (.*);

    always @(negedge clk) begin
        #5;
        if (ser_valid && ser_ready && ln < 32) begin
            lk[ln] = ser_kind;
            ld[ln] = ser_data;
            ln++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_send();
        send_req = 1'b1; step(1); send_req = 1'b0;
    endtask

    task automatic pulse_hrst();
        hrst_req = 1'b1; step(1); hrst_req = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        data_wr = 1'b1; data_val = b; step(1); data_wr = 1'b0;
    endtask

    task automatic set_size(input logic [9:0] s);
        size_wr = 1'b1; size_val = s; step(1); size_wr = 1'b0;
    endtask

    task automatic tidy();
        rx_busy = 0; line_noisy = 0; line_idle = 1; ser_ready = 1; mode = 0;
        flag_clr = '1; step(1); flag_clr = '0; step(1);
        ln = 0;
    endtask

    task automatic wait_flag(input int idx, input int max);
        for (int i = 0; i < max; i++) begin
            if (flags[idx]) break;
            step(1);
        end
    endtask

    task automatic t_reset();
        chk("R10 flags after reset", flags, 0);
        chk("R10 valid after reset", ser_valid, 0);
        chk("R10 count after reset", pay_left, 0);
        chk("R2 pend after reset", {send_pend, hrst_pend}, 0);
    endtask

    task automatic t_packet();
        logic [7:0] rest [0:1];
        int idx = 0, reqs = 0;
        rest[0] = 8'hB2; rest[1] = 8'hC3;
        tidy();
        set_size(10'd3);
        chk("R3 size load", pay_left, 3);
        wr_byte(8'hA1);
        chk("R3 decrement", pay_left, 2);
        wr_byte(8'hEE);
        chk("R3 write ignored when full", pay_left, 2);
        send_req = 1'b1; step(1); send_req = 1'b0;
        chk("R2 send pending one cycle", send_pend, 1);
        step(1);
        chk("R2 send self-cleared", send_pend, 0);
        for (int i = 0; i < 40 && !flags[1]; i++) begin
            if (txreq && idx < 2) begin
                reqs++;
                data_wr = 1'b1; data_val = rest[idx]; idx++;
                step(1); data_wr = 1'b0;
            end else step(1);
        end
        step(1);
        chk("R4 request seen per owed byte", reqs, 2);
        chk("R1 sent flag", flags, 6'b000010);
        chk("R5 no underrun with prompt writes", flags[5], 0);
        chk("R1 item count", ln, 5);
        chk("R1 item0 ordset", {lk[0], ld[0]}, {3'd0, 20'h5A3C1});
        chk("R1 item1 data", {lk[1], ld[1]}, {3'd1, 20'h000A1});
        chk("R1 item2 data", {lk[2], ld[2]}, {3'd1, 20'h000B2});
        chk("R1 item3 data", {lk[3], ld[3]}, {3'd1, 20'h000C3});
        chk("R1 item4 eop", lk[4], 3'd2);
        chk("R4 no request after last", txreq, 0);
        wr_byte(8'h11);
        chk("R3 write ignored at zero count", pay_left, 0);
        flag_clr = 6'b000010; step(1); flag_clr = '0;
        chk("R11 write-one clears sent", flags, 0);
    endtask

    task automatic t_underrun();
        tidy();
        set_size(10'd2);
        wr_byte(8'h77);
        pulse_send();
        wait_flag(5, 20);
        step(1);
        chk("R5 underrun flag", flags, 6'b100000);
        chk("R5 items before underrun", ln, 2);
        chk("R5 data before underrun", {lk[1], ld[1]}, {3'd1, 20'h00077});
        chk("R5 count flushed", pay_left, 0);
    endtask

    task automatic t_crst();
        tidy();
        mode = 2'd1;
        pulse_send();
        wait_flag(1, 10);
        step(1);
        chk("R1 cable reset sent", flags, 6'b000010);
        chk("R1 cable reset single item", ln, 1);
        chk("R1 cable reset kind", lk[0], 3'd4);
    endtask

    task automatic t_invalid();
        tidy();
        mode = 2'd3;
        pulse_send();
        step(4);
        chk("R1 invalid mode discarded", flags, 6'b000001);
        chk("R1 invalid mode no items", ln, 0);
    endtask

    task automatic t_discard();
        tidy();
        rx_busy = 1; line_idle = 0;
        pulse_send();
        step(8);
        chk("R6 discard waits for idle", flags, 0);
        chk("R6 send cleared on discard", send_pend, 0);
        rx_busy = 0; line_idle = 1;
        step(2);
        chk("R6 discard flag once idle", flags, 6'b000001);
        chk("R6 no items", ln, 0);
    endtask

    task automatic t_abort();
        tidy();
        ser_ready = 0;
        set_size(10'd1);
        wr_byte(8'h42);
        pulse_send();
        step(3);
        chk("R7 ordset on offer", {ser_valid, ser_kind}, 4'b1000);
        pulse_hrst();
        step(3);
        ser_ready = 1;
        wait_flag(4, 10);
        step(1);
        chk("R7 abort, hrst sent, no sent", flags, 6'b010100);
        chk("R7 only hrst item", ln, 1);
        chk("R7 item kind", lk[0], 3'd3);
        chk("R7 payload flushed", pay_left, 0);
    endtask

    task automatic t_hrst();
        tidy();
        rx_busy = 1;
        pulse_hrst();
        step(2);
        chk("R8 hrst discarded", flags, 6'b001000);
        chk("R8 hrst pend cleared", hrst_pend, 0);
        tidy();
        set_size(10'd0);
        send_req = 1; hrst_req = 1; step(1); send_req = 0; hrst_req = 0;
        step(10);
        chk("R8 hrst before send", lk[0], 3'd3);
        chk("R8 then empty packet", ln, 3);
        chk("R8 packet ends eop", lk[2], 3'd2);
        chk("R8 hrst sent and sent", flags, 6'b010010);
    endtask

    task automatic t_bist();
        tidy();
        mode = 2'd2;
        pulse_send();
        step(25);
        pulse_hrst();
        step(5);
        chk("R9 carrier pattern continues", {ser_valid, ser_kind}, 4'b1101);
        en = 0; step(1);
        chk("R10 disable stops output", ser_valid, 0);
        chk("R10 disable clears pend", hrst_pend, 0);
        chk("R10 disable clears flags", flags, 0);
        en = 1; step(1);
    endtask

    initial begin
        step(3); rst_n = 1; step(1); en = 1; step(1);
        t_reset();
        t_packet();
        t_underrun();
        t_crst();
        t_invalid();
        t_discard();
        t_abort();
        t_hrst();
        t_bist();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule